// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sits beside a small 8-bit processor core and manages its low-power states. Software reaches it over the special-function-register (SFR) write/read bus. A power control register holds the mode requests, a slow-down enable, two free flag bits and a baud-doubling bit that this block only stores. A second, banked control register shares address 0x88 with a register outside the block. A map bit in a system register at 0xB1 decides which of the two answers at that address.

A low-power mode starts only after two writes in a row. The first write sets an enable bit and the very next SFR write sets the matching start bit. The block drives three outputs: a CPU clock enable, a peripheral clock enable and an oscillator enable. Downstream clock-gate cells use these to stop the clocks. In idle only the CPU clock stops, and an interrupt brings the core back. In power-down every clock and the oscillator stop, and only reset or the external wake pin restarts them. A slow-down mode divides both clock enables by 32. It stays active during idle, and it switches on or off only at a divider period boundary.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `pm_state` is 0 (run), and `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1.
- R2: The power control register is at 0x87, with bit 7 baud-double, 6 power-down start, 5 idle start, 4 slow-down, 3 flag 1, 2 flag 0, 1 power-down enable, 0 idle enable. Bits 7, 4, 3 and 2 read back as written. The start bits always read 0. The flag bits and the baud bit have no effect on the outputs or the mode.
- R3: If the previous SFR write left bit 0 set, a write to 0x87 with bit 5 set puts `pm_state` at 1 (idle) from the next cycle. In idle `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay active.
- R4: A start bit has no effect unless its enable bit was set by the previous SFR write. An enable set in the same write does not count. While in run, the mode never changes without an SFR write.
- R5: Any SFR write that does not start a mode clears both enable bits, unless it is a write to 0x87 that sets them again. Entering a mode also clears both enable bits.
- R6: If the previous write left bit 1 set, a write to 0x87 with bit 6 set puts `pm_state` at 2 (power-down) from the next cycle. In power-down all three enable outputs are 0.
- R7: When both modes are armed and started in the same write, power-down is entered.
- R8: In idle, `irq_wake` high at a clock edge returns the block to run after that edge.
- R9: In power-down only `ext_wake` (or reset) returns the block to run. `irq_wake` has no effect.
- R10: With bit 4 set, `cpu_clk_en` (in run) and `per_clk_en` (in run and in idle) are single-cycle pulses exactly 32 cycles apart.
- R11: Slow-down turns on or off only at a divider period boundary. When it turns on, the gap from the last full-rate pulse to the first slow pulse is exactly 32 cycles.
- R12: While bit 4 of register 0xB1 is 1, address 0x88 reads and writes the banked register. While that bit is 0, writes to 0x88 are ignored and 0x88 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` (combinational) |
| irq_wake | input | 1 | An enabled interrupt is pending |
| ext_wake | input | 1 | External power-down wake pin |
| cpu_clk_en | output | 1 | Enable for the CPU clock gate |
| per_clk_en | output | 1 | Enable for the peripheral clock gate |
| osc_en | output | 1 | Oscillator run enable |
| pm_state | output | 2 | Current mode: 0 run, 1 idle, 2 power-down |

## Verification
Mode changes and register updates are registered on the write or wake edge. The bench therefore drives each stimulus on a falling edge and samples on the next falling edge, half a cycle after the register has taken the new value. Read data is combinational, so readback is sampled with the address held after the write. Divider behaviour cannot be checked in a single cycle, so the bench records the cycle index of every high enable over a window and compares the gaps against 32. It also checks that pulses are one cycle wide, which shows up as a gap of 1.

// File: rtl/pwr_pkg.sv
// Shared definitions for the power mode controller: mode encoding and
// bit positions inside the power control register.
package pwr_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pm_state_e;

    localparam int BIT_IDLE_EN = 0;
    localparam int BIT_PD_EN   = 1;
    localparam int BIT_SLOW    = 4;
    localparam int BIT_IDLE_GO = 5;
    localparam int BIT_PD_GO   = 6;

endpackage

// File: rtl/pwr_sfr_regs.sv
// SFR register file of the power mode controller.
// Holds the power control register, the map bit of the system register and
// the banked register. Decodes the two-step entry into start pulses.
// Assumes one write per strobe cycle. Reads are combinational.
module pwr_sfr_regs #(
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter logic [7:0]  PCON_ADDR = 8'h87,
    parameter logic [7:0]  BANK_ADDR = 8'h88,
    parameter logic [7:0]  SYS_ADDR  = 8'hB1,
    parameter int          MAP_BIT   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          slow_req,
    output logic          idle_go,
    output logic          pd_go
);
    import pwr_pkg::*;

    localparam logic [DW-1:0] START_MASK = DW'((1 << BIT_IDLE_GO) | (1 << BIT_PD_GO));
    localparam logic [DW-1:0] EN_MASK    = DW'((1 << BIT_IDLE_EN) | (1 << BIT_PD_EN));

    logic [DW-1:0] pcon_q;
    logic [DW-1:0] bank_q;
    logic          map_q;
    logic          pcon_hit, sys_hit, bank_hit;

    // Address decode and two-step start detection against the stored enables.
    always_comb begin
        pcon_hit = we && (addr == AW'(PCON_ADDR));
        sys_hit  = we && (addr == AW'(SYS_ADDR));
        bank_hit = we && (addr == AW'(BANK_ADDR)) && map_q;
        idle_go  = pcon_hit && wdata[BIT_IDLE_GO] && pcon_q[BIT_IDLE_EN];
        pd_go    = pcon_hit && wdata[BIT_PD_GO] && pcon_q[BIT_PD_EN];
    end

    // Power control register: start bits never stored, enables live one write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcon_q <= '0;
        end else if (pcon_hit) begin
            if (idle_go || pd_go)
                pcon_q <= wdata & ~(START_MASK | EN_MASK);
            else
                pcon_q <= wdata & ~START_MASK;
        end else if (we) begin
            pcon_q <= pcon_q & ~EN_MASK;
        end
    end

    // Map bit of the system register and the banked register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q  <= 1'b0;
            bank_q <= '0;
        end else begin
            if (sys_hit)  map_q  <= wdata[MAP_BIT];
            if (bank_hit) bank_q <= wdata;
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        if (addr == AW'(PCON_ADDR))
            rdata = pcon_q;
        else if (addr == AW'(SYS_ADDR))
            rdata = DW'(map_q) << MAP_BIT;
        else if (addr == AW'(BANK_ADDR) && map_q)
            rdata = bank_q;
    end

    assign slow_req = pcon_q[BIT_SLOW];

endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode state machine: run, idle, power-down.
// Power-down wins over idle. Idle leaves on an interrupt and power-down
// leaves on the external wake pin. Start pulses are only seen in run.
module pwr_mode_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idle_go,
    input  logic                pd_go,
    input  logic                irq_wake,
    input  logic                ext_wake,
    output pwr_pkg::pm_state_e  state
);
    import pwr_pkg::*;

    pm_state_e state_d;

    // Next-state selection with power-down priority.
    always_comb begin
        state_d = state;
        unique case (state)
            PM_RUN: begin
                if (pd_go)        state_d = PM_DOWN;
                else if (idle_go) state_d = PM_IDLE;
            end
            PM_IDLE: if (irq_wake) state_d = PM_RUN;
            PM_DOWN: if (ext_wake) state_d = PM_RUN;
            default:               state_d = PM_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PM_RUN;
        else        state <= state_d;
    end

endmodule

// File: rtl/pwr_clk_div.sv
// Slow-down divider. Produces a base clock enable that is always high at
// full rate and one cycle in DIV at slow rate. The rate changes only in
// the last cycle of a divider period, so no pulse is cut short. Frozen while
// the oscillator is stopped.
module pwr_clk_div #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_run,
    input  logic slow_req,
    output logic base_en
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          slow_q;
    logic          wrap;

    assign wrap = (cnt_q == LAST);

    // Free-running period counter and boundary-aligned rate switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slow_q <= 1'b0;
        end else if (osc_run) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap) slow_q <= slow_req;
        end
    end

    // Base enable: every cycle at full rate, last period cycle when slow.
    assign base_en = slow_q ? wrap : 1'b1;

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power mode controller top. Joins the SFR registers, the mode state
// machine and the slow-down divider, and forms the clock-gate enables.
// Assumes the CPU issues no SFR writes while its clock is gated.
module pwr_mode_ctrl #(
    parameter int DIV     = 32,
    parameter int MAP_BIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sfr_we,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    input  logic       irq_wake,
    input  logic       ext_wake,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic [1:0] pm_state
);
    import pwr_pkg::*;

    logic      slow_req, idle_go, pd_go, base_en;
    pm_state_e state;

    pwr_sfr_regs #(
        .AW(8), .DW(8), .PCON_ADDR(8'h87), .BANK_ADDR(8'h88),
        .SYS_ADDR(8'hB1), .MAP_BIT(MAP_BIT)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(sfr_we), .addr(sfr_addr),
        .wdata(sfr_wdata), .rdata(sfr_rdata), .slow_req(slow_req),
        .idle_go(idle_go), .pd_go(pd_go)
    );

    pwr_mode_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .idle_go(idle_go), .pd_go(pd_go),
        .irq_wake(irq_wake), .ext_wake(ext_wake), .state(state)
    );

    pwr_clk_div #(.DIV(DIV)) div_i (
        .clk(clk), .rst_n(rst_n), .osc_run(state != PM_DOWN),
        .slow_req(slow_req), .base_en(base_en)
    );

    // Clock-gate enables per mode.
    always_comb begin
        osc_en     = (state != PM_DOWN);
        per_clk_en = (state != PM_DOWN) && base_en;
        cpu_clk_en = (state == PM_RUN) && base_en;
        pm_state   = state;
    end

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Assertion checker for the power mode controller, bound to the top.
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sfr_we,
    input logic       irq_wake,
    input logic       ext_wake,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic [1:0] pm_state
);
    import pwr_pkg::*;

    assert_idle_gates_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_IDLE) |-> (!cpu_clk_en && osc_en));

    assert_run_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_RUN && !sfr_we) |=> (pm_state == PM_RUN));

    assert_down_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_DOWN) |-> (!osc_en && !cpu_clk_en && !per_clk_en));

    assert_idle_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_IDLE && irq_wake) |=> (pm_state == PM_RUN));

    assert_down_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == PM_DOWN && !ext_wake) |=> (pm_state == PM_DOWN));

    assert_valid_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state != 2'd3));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .irq_wake(irq_wake),
    .ext_wake(ext_wake), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .pm_state(pm_state)
);

// File: tb/pwr_mode_ctrl_tb.sv
// Self-checking bench for the power mode controller.
module pwr_mode_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // {address, write data, expected readback}
    localparam logic [23:0] VEC [NV] = '{
        24'h87_8C_8C, 24'h87_0C_0C, 24'h88_5A_00, 24'hB1_10_10, 24'h88_5A_5A,
        24'h87_02_02, 24'h87_08_08, 24'hB1_00_00, 24'h88_33_00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       irq_wake = 1'b0;
    logic       ext_wake = 1'b0;
    logic       cpu_clk_en, per_clk_en, osc_en;
    logic [1:0] pm_state;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_wake(irq_wake),
        .ext_wake(ext_wake), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .pm_state(pm_state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Packs {state, cpu, per, osc} for one compare.
    function automatic int outs();
        return {pm_state, cpu_clk_en, per_clk_en, osc_en};
    endfunction

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic read_check(input logic [7:0] a, input logic [7:0] exp, input string req);
        sfr_addr = a;
        #1;
        check(sfr_rdata == exp, req, sfr_rdata, exp);
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_wake = 1'b1;
        @(negedge clk); irq_wake = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_wake = 1'b1;
        @(negedge clk); ext_wake = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(outs() == 5'b00111, "R1 outputs", outs(), 5'b00111);
        read_check(8'h87, 8'h00, "R1 pcon");
        read_check(8'hB1, 8'h00, "R1 sys");

        // R2 / R12: register vectors; flags and baud bit leave outputs alone
        for (int i = 0; i < NV; i++) begin
            sfr_write(VEC[i][23:16], VEC[i][15:8]);
            read_check(VEC[i][23:16], VEC[i][7:0], "R2/R12 vector");
            check(outs() == 5'b00111, "R2 no effect", outs(), 5'b00111);
        end

        // R3: idle entry; start and enable bits read 0 after wake
        sfr_write(8'h87, 8'h01);
        sfr_write(8'h87, 8'h20);
        check(outs() == 5'b01011, "R3 idle", outs(), 5'b01011);
        pulse_irq();
        check(outs() == 5'b00111, "R8 wake", outs(), 5'b00111);
        read_check(8'h87, 8'h00, "R3 bits cleared");

        // R4: enable and start in the same write do not enter; lone start neither
        sfr_write(8'h87, 8'h21);
        check(pm_state == 2'd0, "R4 same write", pm_state, 0);
        sfr_write(8'h87, 8'h00);
        sfr_write(8'h87, 8'h60);
        check(pm_state == 2'd0, "R4 lone start", pm_state, 0);

        // R5: an unrelated write disarms the enable
        sfr_write(8'h87, 8'h01);
        sfr_write(8'hB1, 8'h00);
        read_check(8'h87, 8'h00, "R5 enable cleared");
        sfr_write(8'h87, 8'h20);
        check(pm_state == 2'd0, "R5 no idle", pm_state, 0);

        // R6 / R9: power-down, interrupt ignored, external pin wakes
        sfr_write(8'h87, 8'h02);
        sfr_write(8'h87, 8'h40);
        check(outs() == 5'b10000, "R6 down", outs(), 5'b10000);
        pulse_irq();
        repeat (3) @(negedge clk);
        check(outs() == 5'b10000, "R9 irq ignored", outs(), 5'b10000);
        pulse_ext();
        check(outs() == 5'b00111, "R9 ext wake", outs(), 5'b00111);

        // R7: both armed and started: power-down wins
        sfr_write(8'h87, 8'h03);
        sfr_write(8'h87, 8'h60);
        check(pm_state == 2'd2, "R7 priority", pm_state, 2);
        pulse_ext();
        read_check(8'h87, 8'h00, "R7 bits cleared");

        // R10 / R11: slow-down switch-on boundary and pulse spacing in run
        begin
            int last_hi = -1, g1 = 0, g2 = 0;
            bit seen_low = 1'b0;
            sfr_write(8'h87, 8'h10);
            for (int i = 0; i < 110; i++) begin
                @(negedge clk);
                if (cpu_clk_en) begin
                    if (seen_low && g1 == 0)      g1 = i - last_hi;
                    else if (seen_low && g2 == 0) g2 = i - last_hi;
                    last_hi = i;
                end else begin
                    seen_low = 1'b1;
                end
            end
            check(g1 == 32, "R11 first slow gap", g1, 32);
            check(g2 == 32, "R10 slow period", g2, 32);
        end

        // R10: slow rate kept in idle on the peripheral enable
        begin
            int first = -1, second = -1;
            bit cpu_hi = 1'b0;
            sfr_write(8'h87, 8'h11);
            sfr_write(8'h87, 8'h30);
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (cpu_clk_en) cpu_hi = 1'b1;
                if (per_clk_en) begin
                    if (first < 0)       first = i;
                    else if (second < 0) second = i;
                end
            end
            check(second - first == 32, "R10 idle period", second - first, 32);
            check(!cpu_hi, "R10 cpu gated in idle", cpu_hi, 0);
            pulse_irq();
            check(pm_state == 2'd0, "R8 wake slow", pm_state, 0);
        end

        // R11: slow-down off returns to full rate after the boundary
        begin
            int highs = 0;
            sfr_write(8'h87, 8'h00);
            repeat (40) @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (cpu_clk_en) highs++;
                @(negedge clk);
            end
            check(highs == 4, "R11 full rate", highs, 4);
        end

        finish_run();
    end
endmodule